// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Frame Error Flags

This block receives asynchronous serial characters from a single idle-high line. A programmable divider sets the oversampling tick rate. Each bit lasts 16 ticks, or 8 ticks when double speed is selected. The receiver finds the falling edge that starts a character and confirms the start bit at mid-bit. It decides every bit by a majority of three samples around the bit centre. It assembles 5 to 9 data bits, then checks an optional even or odd parity bit and the first stop bit.

Each finished character goes into a single holding register. A frame error flag and a parity error flag are stored beside it and describe that character. A separate overrun flag records that a newer character was lost because the held one had not been read yet. A read strobe empties the holding register. An interrupt request follows the full state, gated by an enable input. In multi-processor mode, characters whose ninth bit is clear are dropped, so the host only sees address characters.

Top module: `serial_rx_errbuf`

## Requirements
- R1: The character length follows `size_code`: 000=5, 001=6, 010=7, 011=8, 111=9 data bits; other codes give 8. Bits arrive least significant first and land from bit 0 of `rx_data` upward, and unused upper bits read 0.
- R2: In 9-bit mode the last data bit appears on `rx_bit9`; in shorter modes `rx_bit9` reads 0.
- R3: `rx_full` rises once a character is stored. A cycle with `rd_stb` high while full clears `rx_full`, `err_frame`, `err_parity` and `err_overrun`.
- R4: `err_frame` is 1 for a stored character whose first stop bit was decided low. The data is still delivered.
- R5: `par_mode` 00 means no parity bit, 10 means even and 11 means odd (code 01 is treated as none). `err_parity` is 1 for a stored character whose data bits plus parity bit do not have the configured parity.
- R6: If a character completes while `rx_full` is high and no read happens in that cycle, the held character and its flags are kept, the new one is dropped, and `err_overrun` goes to 1.
- R7: `irq` is 1 exactly when `irq_en` and `rx_full` were both 1 one clock earlier.
- R8: With `mp_mode` high, a character whose ninth bit is 0 is discarded and leaves `rx_full` and all flags unchanged; a character with ninth bit 1 is stored. Characters shorter than 9 bits count as having ninth bit 0.
- R9: With `dbl_speed` high a bit lasts 8 ticks instead of 16.
- R10: A low pulse shorter than half a bit does not start a character, because the start bit is rechecked at mid-bit.
- R11: A single-tick disturbance at a bit centre does not change the decided bit value.
- R12: While `rx_en` is low the line is ignored, a partly received character is abandoned, and the stored character and its flags do not change.
- R13: After reset `rx_full`, all flags, `irq` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial line, idle high |
| baud_div | input | DIV_W | Oversampling tick every baud_div+1 clocks |
| dbl_speed | input | 1 | 8 ticks per bit instead of 16 |
| size_code | input | 3 | Character length select |
| par_mode | input | 2 | Parity select |
| mp_mode | input | 1 | Drop characters whose ninth bit is 0 |
| irq_en | input | 1 | Interrupt enable |
| rd_stb | input | 1 | Read strobe, empties the holding register |
| rx_data | output | 8 | Received data bits 0..7 |
| rx_bit9 | output | 1 | Ninth received data bit |
| rx_full | output | 1 | Unread character held |
| err_frame | output | 1 | Stop bit of held character was low |
| err_parity | output | 1 | Parity mismatch in held character |
| err_overrun | output | 1 | A character was lost while full |
| irq | output | 1 | Gated receive-complete request |

## Verification
The bench uses the default parameters: DIV_W of 12, a two-stage synchronizer, and 16 or 8 ticks per bit. It drives `baud_div` to 1, so one bit lasts 32 clocks at normal speed and 16 at double speed. Every character length, both parity senses, both oversampling rates and the overrun and address-filter paths then fit in a short run. At this rate a two-clock glitch covers exactly one tick sample, so the start recheck and the majority vote can be exercised deliberately.

// File: rtl/rxe_pkg.sv
package rxe_pkg;
  localparam int FRAME_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic [FRAME_W-1:0] data;
    logic               ferr;
    logic               perr;
  } rx_frame_t;

  // number of data bits for a length code; unlisted codes fall back to 8
  function automatic logic [3:0] len_of(input logic [2:0] code);
    case (code)
      3'b000:  len_of = 4'd5;
      3'b001:  len_of = 4'd6;
      3'b010:  len_of = 4'd7;
      3'b111:  len_of = 4'd9;
      default: len_of = 4'd8;
    endcase
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    vote3 = (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/rxe_sync.sv
module rxe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxe_tick.sv
module rxe_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rxe_deframe.sv
module rxe_deframe
  import rxe_pkg::*;
#(
  parameter int OSR_NORM = 16,
  parameter int OSR_FAST = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      tick,
  input  logic      line,
  input  logic      dbl,
  input  logic [2:0] size_code,
  input  logic [1:0] par_mode,
  output logic      done,
  output rx_frame_t frame
);
  localparam int CNT_W = $clog2(OSR_NORM);

  rx_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic [3:0]         bit_idx;
  logic [1:0]         smp;
  logic               prev;
  logic [FRAME_W-1:0] shreg;
  logic               par_bit;

  logic [CNT_W-1:0]   mid, last;
  logic [3:0]         nbits;
  logic               in_window, at_decide, at_end, bit_val, par_on;

  always_comb begin
    mid       = dbl ? CNT_W'(OSR_FAST / 2) : CNT_W'(OSR_NORM / 2);
    last      = dbl ? CNT_W'(OSR_FAST - 1) : CNT_W'(OSR_NORM - 1);
    nbits     = len_of(size_code);
    par_on    = par_mode[1];
    in_window = (cnt == mid - 1'b1) || (cnt == mid);
    at_decide = (cnt == mid + 1'b1);
    at_end    = (cnt == last);
    bit_val   = vote3(smp[1], smp[0], line);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      smp     <= '0;
      prev    <= 1'b1;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      frame   <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= line;
        if (state == ST_IDLE) begin
          if (prev && !line) begin
            state   <= ST_START;
            cnt     <= CNT_W'(1);
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
          end
        end else begin
          if (in_window) smp <= {smp[0], line};
          if (at_end) cnt <= '0;
          else        cnt <= cnt + 1'b1;

          if (at_decide) begin
            case (state)
              ST_START: if (bit_val) state <= ST_IDLE;
              ST_DATA:  shreg[bit_idx] <= bit_val;
              ST_PAR:   par_bit <= bit_val;
              ST_STOP: begin
                done       <= 1'b1;
                frame.data <= shreg;
                frame.ferr <= !bit_val;
                frame.perr <= par_on & ((^shreg) ^ par_bit ^ par_mode[0]);
                state      <= ST_IDLE;
              end
              default: state <= ST_IDLE;
            endcase
          end

          if (at_end) begin
            case (state)
              ST_START: begin
                state   <= ST_DATA;
                bit_idx <= '0;
              end
              ST_DATA: begin
                if (bit_idx == nbits - 1'b1) state <= par_on ? ST_PAR : ST_STOP;
                else                         bit_idx <= bit_idx + 1'b1;
              end
              ST_PAR:  state <= ST_STOP;
              default: state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  // a disabled receiver never reports a completed character
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !done); // R12

  // a high vote at the start-bit centre always returns to idle
  AST_START_RECHECK: assert property (@(posedge clk) disable iff (rst || !en)
    (tick && state == ST_START && at_decide && bit_val) |=> state == ST_IDLE); // R10
endmodule

// File: rtl/rxe_holdbuf.sv
module rxe_holdbuf
  import rxe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               done,
  input  rx_frame_t          frame,
  input  logic               rd,
  input  logic               mp_mode,
  input  logic               irq_en,
  output logic [FRAME_W-1:0] data,
  output logic               full,
  output logic               ferr,
  output logic               perr,
  output logic               ovr,
  output logic               irq
);
  logic accept, load, lose, drain;

  always_comb begin
    accept = done && !(mp_mode && !frame.data[FRAME_W-1]);
    load   = accept && (!full || rd);
    lose   = accept && full && !rd;
    drain  = rd && full && !accept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
      full <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
      ovr  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= irq_en && full;
      if (load) begin
        data <= frame.data;
        ferr <= frame.ferr;
        perr <= frame.perr;
        full <= 1'b1;
        ovr  <= 1'b0;
      end else if (lose) begin
        ovr <= 1'b1;
      end else if (drain) begin
        full <= 1'b0;
        ferr <= 1'b0;
        perr <= 1'b0;
        ovr  <= 1'b0;
      end
    end
  end

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (done && full && !rd && (frame.data[FRAME_W-1] || !mp_mode)) |=> ($stable(data) && ovr)); // R6

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (rd && !done) |=> !full); // R3

  AST_FLAGS_NEED_FULL: assert property (@(posedge clk) disable iff (rst)
    (ferr || perr || ovr) |-> full); // R4

  AST_MP_DROP: assert property (@(posedge clk) disable iff (rst)
    (done && mp_mode && !frame.data[FRAME_W-1] && !rd) |=> $stable(full)); // R8
endmodule

// File: rtl/serial_rx_errbuf.sv
module serial_rx_errbuf
  import rxe_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int OSR_NORM    = 16,
  parameter int OSR_FAST    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             rxd,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             dbl_speed,
  input  logic [2:0]       size_code,
  input  logic [1:0]       par_mode,
  input  logic             mp_mode,
  input  logic             irq_en,
  input  logic             rd_stb,
  output logic [7:0]       rx_data,
  output logic             rx_bit9,
  output logic             rx_full,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun,
  output logic             irq
);
  logic               line_s, tick, fr_done;
  rx_frame_t          fr;
  logic [FRAME_W-1:0] held;

  rxe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  rxe_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(rx_en), .div(baud_div), .tick(tick)
  );

  rxe_deframe #(.OSR_NORM(OSR_NORM), .OSR_FAST(OSR_FAST)) u_deframe (
    .clk(clk), .rst(rst), .en(rx_en), .tick(tick), .line(line_s),
    .dbl(dbl_speed), .size_code(size_code), .par_mode(par_mode),
    .done(fr_done), .frame(fr)
  );

  rxe_holdbuf u_buf (
    .clk(clk), .rst(rst), .done(fr_done), .frame(fr), .rd(rd_stb),
    .mp_mode(mp_mode), .irq_en(irq_en), .data(held), .full(rx_full),
    .ferr(err_frame), .perr(err_parity), .ovr(err_overrun), .irq(irq)
  );

  assign rx_data = held[7:0];
  assign rx_bit9 = held[FRAME_W-1];

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_full) && $past(irq_en)); // R7
endmodule

// File: tb/serial_rx_errbuf_bench.sv
module serial_rx_errbuf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0;
  logic        rxd = 1'b1;
  logic [11:0] baud_div = 12'd1;
  logic        dbl_speed = 1'b0;
  logic [2:0]  size_code = 3'b011;
  logic [1:0]  par_mode = 2'b00;
  logic        mp_mode = 1'b0;
  logic        irq_en = 1'b0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_bit9, rx_full, err_frame, err_parity, err_overrun, irq;

  int errors = 0;
  int checks = 0;
  int bclk   = 32;

  always #4 clk = ~clk;

  serial_rx_errbuf u_serial_rx_errbuf (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rxd(rxd), .baud_div(baud_div),
    .dbl_speed(dbl_speed), .size_code(size_code), .par_mode(par_mode),
    .mp_mode(mp_mode), .irq_en(irq_en), .rd_stb(rd_stb),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_full(rx_full),
    .err_frame(err_frame), .err_parity(err_parity),
    .err_overrun(err_overrun), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    @(negedge clk) rxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input bit par_on,
                      input bit pbit, input bit stop_v);
    drive(1'b0, bclk);
    for (int i = 0; i < nb; i++) drive(d[i], bclk);
    if (par_on) drive(pbit, bclk);
    drive(stop_v, bclk);
    drive(1'b1, 2 * bclk);
  endtask

  task automatic do_read();
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R13 full", rx_full, 0);
    chk("R13 flags", {err_frame, err_parity, err_overrun}, 0);
    chk("R13 irq", irq, 0);
    chk("R13 data", rx_data, 0);
  endtask

  task automatic t_basic8();
    size_code = 3'b011; par_mode = 2'b00;
    send(9'h0A5, 8, 0, 0, 1);
    chk("R1 data 8-bit", rx_data, 8'hA5);
    chk("R3 full set", rx_full, 1);
    chk("R2 bit9 zero", rx_bit9, 0);
    chk("R4 no ferr", err_frame, 0);
    do_read();
    chk("R3 read clears", rx_full, 0);
  endtask

  task automatic t_sizes();
    size_code = 3'b000;
    send(9'h1F5, 5, 0, 0, 1);
    chk("R1 5-bit", rx_data, 8'h15);
    do_read();
    size_code = 3'b010;
    send(9'h1D3, 7, 0, 0, 1);
    chk("R1 7-bit", rx_data, 8'h53);
    do_read();
    size_code = 3'b111;
    send(9'h15A, 9, 0, 0, 1);
    chk("R2 bit9", rx_bit9, 1);
    chk("R2 low byte", rx_data, 8'h5A);
    do_read();
    size_code = 3'b011;
  endtask

  task automatic t_parity();
    par_mode = 2'b10;
    send(9'h0B1, 8, 1, ^8'hB1, 1);
    chk("R5 even ok", err_parity, 0);
    do_read();
    send(9'h0B1, 8, 1, ~(^8'hB1), 1);
    chk("R5 even bad", err_parity, 1);
    chk("R5 data kept", rx_data, 8'hB1);
    do_read();
    chk("R3 perr cleared", err_parity, 0);
    par_mode = 2'b11;
    send(9'h03C, 8, 1, ~(^8'h3C), 1);
    chk("R5 odd ok", err_parity, 0);
    do_read();
    send(9'h03C, 8, 1, ^8'h3C, 1);
    chk("R5 odd bad", err_parity, 1);
    do_read();
    par_mode = 2'b00;
  endtask

  task automatic t_frame_err();
    send(9'h066, 8, 0, 0, 0);
    chk("R4 ferr", err_frame, 1);
    chk("R4 data", rx_data, 8'h66);
    do_read();
    chk("R3 ferr cleared", err_frame, 0);
  endtask

  task automatic t_overrun();
    send(9'h011, 8, 0, 0, 1);
    send(9'h022, 8, 0, 0, 1);
    chk("R6 ovr", err_overrun, 1);
    chk("R6 old kept", rx_data, 8'h11);
    chk("R6 full", rx_full, 1);
    do_read();
    chk("R3 ovr cleared", err_overrun, 0);
  endtask

  task automatic t_irq();
    irq_en = 1'b1;
    send(9'h042, 8, 0, 0, 1);
    chk("R7 irq on", irq, 1);
    @(negedge clk) irq_en = 1'b0;
    @(negedge clk);
    chk("R7 irq gated", irq, 0);
    do_read();
    @(negedge clk) irq_en = 1'b1;
    @(negedge clk);
    chk("R7 irq empty", irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_mp();
    size_code = 3'b111; mp_mode = 1'b1;
    send(9'h0AB, 9, 0, 0, 1);
    chk("R8 drop data frame", rx_full, 0);
    send(9'h1CD, 9, 0, 0, 1);
    chk("R8 keep address", rx_full, 1);
    chk("R8 address data", rx_data, 8'hCD);
    do_read();
    mp_mode = 1'b0; size_code = 3'b011;
  endtask

  task automatic t_dbl();
    dbl_speed = 1'b1; bclk = 16;
    send(9'h0C3, 8, 0, 0, 1);
    chk("R9 dbl data", rx_data, 8'hC3);
    chk("R9 dbl ferr", err_frame, 0);
    do_read();
    dbl_speed = 1'b0; bclk = 32;
  endtask

  task automatic t_glitch();
    drive(1'b0, 4);
    drive(1'b1, 4 * bclk);
    chk("R10 glitch ignored", rx_full, 0);
  endtask

  task automatic t_vote();
    drive(1'b0, bclk);
    for (int i = 0; i < 8; i++) begin
      if (i == 3) begin
        drive(1'b0, 16);
        drive(1'b1, 2);
        drive(1'b0, bclk - 18);
      end else begin
        drive(1'b0, bclk);
      end
    end
    drive(1'b1, 3 * bclk);
    chk("R11 vote full", rx_full, 1);
    chk("R11 vote data", rx_data, 8'h00);
    do_read();
  endtask

  task automatic t_disabled();
    send(9'h077, 8, 0, 0, 1);
    @(negedge clk) rx_en = 1'b0;
    send(9'h099, 8, 0, 0, 1);
    chk("R12 held data", rx_data, 8'h77);
    chk("R12 no ovr", err_overrun, 0);
    do_read();
    send(9'h055, 8, 0, 0, 1);
    chk("R12 ignored", rx_full, 0);
    @(negedge clk) rx_en = 1'b1;
    drive(1'b1, 2 * bclk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    rx_en = 1'b1;
    drive(1'b1, 2 * bclk);
    t_basic8();
    t_sizes();
    t_parity();
    t_frame_err();
    t_overrun();
    t_irq();
    t_mp();
    t_dbl();
    t_glitch();
    t_vote();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule